// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Status Byte

This block is the arithmetic core behind an 8-bit accumulator machine. It holds the accumulator, a second working register and a status byte. A controller gives it an operation code, an 8-bit operand and a one-cycle start strobe. The unit updates its registers and raises a one-cycle done pulse when the result is visible. Instruction decode, operand fetch and memory access stay with the controller.

Most operations finish on the clock edge that samples the start strobe. Unsigned multiply and unsigned divide run as an iterative shift-add or shift-subtract sequence of one step per data bit, with a busy output raised while they run. Both write a 16-bit product or a quotient and remainder pair across the accumulator and the second register. The even-parity bit of the status byte always tracks the accumulator, whatever the last write to the status byte was.

Top module: `acc_alu`

## Requirements
- R1: Reset clears the accumulator, the B register and the status byte; busy and done are low after reset.
- R2: Opcode 0 (add) and opcode 1 (add with carry-in from status bit 7) write A+operand(+carry) to A. Bit 7 takes the carry out of bit 7 and bit 6 takes the carry out of bit 3. Bit 2 is set when the signed sum falls outside -128..127.
- R3: Opcode 2 subtracts the operand and the status bit 7 borrow from A. Bit 7 takes the borrow out of bit 7, bit 6 the borrow out of bit 3, and bit 2 the signed overflow.
- R4: Opcode 3 increments A modulo 256 and leaves status bits 7, 6 and 2 unchanged.
- R5: Opcodes 4, 5 and 6 write A AND, OR and XOR operand to A and leave status bits 7, 6 and 2 unchanged.
- R6: Opcode 7 multiplies A by B unsigned. The low product byte goes to A and the high byte to B. Bit 7 is cleared and bit 2 is set exactly when the product exceeds 255. Done rises 8 clock edges after the start edge.
- R7: Opcode 8 divides A by a non-zero B unsigned. The quotient goes to A and the remainder to B, and bits 7 and 2 are cleared. It has the same 8-edge latency as multiply.
- R8: Opcode 8 with B equal to zero leaves A and B unchanged, sets bit 2 and clears bit 7.
- R9: Busy is high from the start edge of a multiply or divide until its result is written. A start strobe while busy is ignored.
- R10: Status bit 0 always equals the XOR of the accumulator bits, so A plus that bit holds an even number of ones. A direct write to bit 0 has no effect.
- R11: Opcode 11 writes the operand to status bits 7..1. Bits 5, 4, 3 and 1 change only through this write.
- R12: Opcodes 9 and 10 load the operand into A and into B. Every opcode other than 7 and 8 completes on its start edge, with done high for the following cycle.
- R13: Opcodes 12 to 15 change nothing and still produce a done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts the operation on op/operand |
| op | input | 4 | Operation code |
| operand | input | 8 | Second operand or load value |
| acc | output | 8 | Accumulator |
| breg | output | 8 | B register |
| psw | output | 8 | Status byte: 7 carry, 6 half carry, 5..3 user/bank, 2 overflow, 1 user, 0 parity |
| busy | output | 1 | Multiply or divide in progress |
| done | output | 1 | One-cycle pulse after a result is written |

## Verification
A wrong flag computation appears on the status byte in the cycle after the start edge and stays there until the next flag-writing operation. The bench therefore reads it right after each operation. A fault in the iterative multiply or divide stays inside the sequencer until the last step, and only then appears in A, B and the status byte. The bench checks both the values and the exact 9-sample latency to the done pulse. A sequencer that lets a start strobe through while busy corrupts A at once, and the freeze of A and B during busy catches that on the next edge.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int unsigned DATA_W = 8;

  localparam logic [3:0] OP_ADD   = 4'd0;
  localparam logic [3:0] OP_ADDC  = 4'd1;
  localparam logic [3:0] OP_SUBB  = 4'd2;
  localparam logic [3:0] OP_INC   = 4'd3;
  localparam logic [3:0] OP_AND   = 4'd4;
  localparam logic [3:0] OP_OR    = 4'd5;
  localparam logic [3:0] OP_XOR   = 4'd6;
  localparam logic [3:0] OP_MUL   = 4'd7;
  localparam logic [3:0] OP_DIV   = 4'd8;
  localparam logic [3:0] OP_LDA   = 4'd9;
  localparam logic [3:0] OP_LDB   = 4'd10;
  localparam logic [3:0] OP_WRPSW = 4'd11;

  localparam int unsigned ST_CY = 7;
  localparam int unsigned ST_HC = 6;
  localparam int unsigned ST_OV = 2;

  typedef struct packed {
    logic [DATA_W-1:0] res;
    logic              cy;
    logic              hc;
    logic              ov;
  } arith_t;

  // Sum with carry in; half carry taken from the low nibble.
  function automatic arith_t f_add(input logic [DATA_W-1:0] a,
                                   input logic [DATA_W-1:0] b,
                                   input logic cin);
    arith_t    r;
    logic [4:0] lo;
    logic [DATA_W:0] s;
    lo = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, cin};
    s  = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
    r.res = s[DATA_W-1:0];
    r.cy  = s[DATA_W];
    r.hc  = lo[4];
    r.ov  = (a[DATA_W-1] == b[DATA_W-1]) && (s[DATA_W-1] != a[DATA_W-1]);
    return r;
  endfunction

  // Difference with borrow in; flags are borrows.
  function automatic arith_t f_sub(input logic [DATA_W-1:0] a,
                                   input logic [DATA_W-1:0] b,
                                   input logic bin);
    arith_t    r;
    logic [4:0] lo;
    logic [DATA_W:0] s;
    lo = {1'b0, a[3:0]} - {1'b0, b[3:0]} - {4'd0, bin};
    s  = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, bin};
    r.res = s[DATA_W-1:0];
    r.cy  = s[DATA_W];
    r.hc  = lo[4];
    r.ov  = (a[DATA_W-1] != b[DATA_W-1]) && (s[DATA_W-1] != a[DATA_W-1]);
    return r;
  endfunction

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub
  import acc_alu_pkg::*;
(
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic              sub,
  output arith_t            r
);
  always_comb begin
    if (sub) r = f_sub(a, b, cin);
    else     r = f_add(a, b, cin);
  end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   sel,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (sel)
      2'd0:    y = a & b;
      2'd1:    y = a | b;
      2'd2:    y = a ^ b;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/acc_alu_muldiv.sv
module acc_alu_muldiv #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic         go_div,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         busy,
  output logic         fin,
  output logic         is_div,
  output logic         dz,
  output logic [W-1:0] res_lo,
  output logic [W-1:0] res_hi
);
  localparam int unsigned CW   = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          busy_q, div_q, dz_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  m_q, hi_q, lo_q;
  logic [W-1:0]  hi_n, lo_n;

  // One shift-add step: conditionally add multiplicand, shift right.
  function automatic logic [2*W-1:0] f_mul_step(input logic [W-1:0] hi,
                                                input logic [W-1:0] lo,
                                                input logic [W-1:0] m);
    logic [W:0] s;
    s = {1'b0, hi} + (lo[0] ? {1'b0, m} : '0);
    return {s, lo[W-1:1]};
  endfunction

  // One restoring step: shift in dividend bit, subtract if it fits.
  function automatic logic [2*W-1:0] f_div_step(input logic [W-1:0] hi,
                                                input logic [W-1:0] lo,
                                                input logic [W-1:0] m);
    logic [W:0] sh, d;
    sh = {hi, lo[W-1]};
    d  = sh - {1'b0, m};
    if (!d[W]) return {d[W-1:0], lo[W-2:0], 1'b1};
    else       return {sh[W-1:0], lo[W-2:0], 1'b0};
  endfunction

  always_comb begin
    if (div_q) {hi_n, lo_n} = f_div_step(hi_q, lo_q, m_q);
    else       {hi_n, lo_n} = f_mul_step(hi_q, lo_q, m_q);
  end

  assign busy   = busy_q;
  assign fin    = busy_q && (cnt_q == LAST);
  assign is_div = div_q;
  assign dz     = dz_q;
  assign res_lo = lo_n;
  assign res_hi = hi_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      div_q  <= 1'b0;
      dz_q   <= 1'b0;
      cnt_q  <= '0;
      m_q    <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else if (go && !busy_q) begin
      busy_q <= 1'b1;
      div_q  <= go_div;
      dz_q   <= go_div && (b == '0);
      cnt_q  <= '0;
      m_q    <= b;
      hi_q   <= '0;
      lo_q   <= a;
    end else if (busy_q) begin
      hi_q  <= hi_n;
      lo_q  <= lo_n;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] acc,
  output logic [DATA_W-1:0] breg,
  output logic [7:0]        psw,
  output logic              busy,
  output logic              done
);
  logic [DATA_W-1:0] acc_q, b_q;
  logic [7:1]        st_q;
  logic              done_q;

  // Named internal events for the checker.
  logic              take;      // start accepted
  logic              md_go, md_fin, md_isdiv, md_dz, md_busy;
  logic [DATA_W-1:0] md_lo, md_hi, logic_y;
  arith_t            as_r;

  assign take  = start && !md_busy;
  assign md_go = take && ((op == OP_MUL) || (op == OP_DIV));

  acc_alu_addsub u_as (
    .a   (acc_q),
    .b   (operand),
    .cin ((op == OP_ADD) ? 1'b0 : st_q[ST_CY]),
    .sub (op == OP_SUBB),
    .r   (as_r)
  );

  acc_alu_logic #(.W(DATA_W)) u_lg (
    .a   (acc_q),
    .b   (operand),
    .sel (op[1:0]),
    .y   (logic_y)
  );

  acc_alu_muldiv #(.W(DATA_W)) u_md (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (md_go),
    .go_div (op == OP_DIV),
    .a      (acc_q),
    .b      (b_q),
    .busy   (md_busy),
    .fin    (md_fin),
    .is_div (md_isdiv),
    .dz     (md_dz),
    .res_lo (md_lo),
    .res_hi (md_hi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      b_q    <= '0;
      st_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (md_fin) begin
        done_q      <= 1'b1;
        st_q[ST_CY] <= 1'b0;
        if (md_isdiv && md_dz) begin
          st_q[ST_OV] <= 1'b1;
        end else begin
          acc_q       <= md_lo;
          b_q         <= md_hi;
          st_q[ST_OV] <= md_isdiv ? 1'b0 : (md_hi != '0);
        end
      end else if (take) begin
        done_q <= !md_go;
        unique case (op)
          OP_ADD, OP_ADDC, OP_SUBB: begin
            acc_q       <= as_r.res;
            st_q[ST_CY] <= as_r.cy;
            st_q[ST_HC] <= as_r.hc;
            st_q[ST_OV] <= as_r.ov;
          end
          OP_INC:               acc_q <= acc_q + 1'b1;
          OP_AND, OP_OR, OP_XOR: acc_q <= logic_y;
          OP_LDA:               acc_q <= operand;
          OP_LDB:               b_q   <= operand;
          OP_WRPSW:             st_q  <= operand[7:1];
          default: ;
        endcase
      end
    end
  end

  assign acc  = acc_q;
  assign breg = b_q;
  assign psw  = {st_q, ^acc_q};
  assign busy = md_busy;
  assign done = done_q;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [3:0]        op,
  input logic [DATA_W-1:0] acc,
  input logic [DATA_W-1:0] breg,
  input logic              st_cy,
  input logic              st_ov,
  input logic              st_u1,
  input logic              busy,
  input logic              done,
  input logic              md_fin,
  input logic              md_dz
);
  AST_USER_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && !busy && op == OP_WRPSW) |=> $stable(st_u1)); // R11

  AST_BUSY_FREEZES_AB: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (done || ($stable(acc) && $stable(breg)))); // R9

  AST_MD_CLEARS_CY: assert property (@(posedge clk) disable iff (!rst_n)
    md_fin |=> !st_cy); // R6

  AST_DIV_ZERO_OV: assert property (@(posedge clk) disable iff (!rst_n)
    (md_fin && md_dz) |=> st_ov); // R8

  AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R6
endmodule

bind acc_alu acc_alu_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .op     (op),
  .acc    (acc),
  .breg   (breg),
  .st_cy  (psw[7]),
  .st_ov  (psw[2]),
  .st_u1  (psw[1]),
  .busy   (busy),
  .done   (done),
  .md_fin (md_fin),
  .md_dz  (md_dz)
);

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] operand = 8'd0;
  logic [7:0] acc, breg, psw;
  logic       busy, done;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;
  int m_a = 0, m_b = 0, m_psw = 0;

  acc_alu u_dut (.clk(clk), .rst_n(rst_n), .start(start), .op(op), .operand(operand),
                 .acc(acc), .breg(breg), .psw(psw), .busy(busy), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int sgn(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic int par(int v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += (v >> i) & 1;
    return c & 1;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic chk_state(string req);
    chk({req, " A"}, acc, m_a);
    chk({req, " B"}, breg, m_b);
    chk({req, " status"}, psw, (m_psw & 8'hFE) | par(m_a));
  endtask

  // Reference behaviour restated with integer arithmetic.
  task automatic model(int o, int f);
    int c, s, sa, h;
    c = (m_psw >> 7) & 1;
    case (o)
      0, 1: begin
        if (o == 0) c = 0;
        s = m_a + f + c; sa = sgn(m_a) + sgn(f) + c; h = (m_a % 16) + (f % 16) + c;
        m_psw = (m_psw & 8'h3B) | ((s > 255) << 7) | ((h > 15) << 6) | ((sa > 127 || sa < -128) << 2);
        m_a = s % 256;
      end
      2: begin
        s = m_a - f - c; sa = sgn(m_a) - sgn(f) - c; h = (m_a % 16) - (f % 16) - c;
        m_psw = (m_psw & 8'h3B) | ((s < 0) << 7) | ((h < 0) << 6) | ((sa > 127 || sa < -128) << 2);
        m_a = (s + 256) % 256;
      end
      3: m_a = (m_a + 1) % 256;
      4: m_a = m_a & f;
      5: m_a = m_a | f;
      6: m_a = m_a ^ f;
      7: begin
        s = m_a * m_b; m_a = s % 256; m_b = s / 256;
        m_psw = (m_psw & 8'h7B) | ((s > 255) << 2);
      end
      8: begin
        if (m_b == 0) m_psw = (m_psw & 8'h7B) | 4;
        else begin s = m_a; m_a = s / m_b; m_b = s % m_b; m_psw = m_psw & 8'h7B; end
      end
      9:  m_a = f;
      10: m_b = f;
      11: m_psw = f;
      default: ;
    endcase
  endtask

  // Issue one operation, wait for done, check latency and state.
  task automatic run(string req, int o, int f);
    int lat;
    @(negedge clk); op = 4'(o); operand = 8'(f); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0; lat = 1;
    while (!done && lat < 40) begin @(negedge clk); lat++; end
    model(o, f);
    chk({req, " latency"}, lat, (o == 7 || o == 8) ? 9 : 1);
    chk_state(req);
  endtask

  task automatic t_reset();
    chk("R1 A", acc, 0); chk("R1 B", breg, 0); chk("R1 status", psw, 0);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0);
  endtask

  task automatic t_add();
    run("R12 lda", 9, 8'h7F); run("R2 add ov", 0, 8'h01);
    run("R12 lda", 9, 8'hFF); run("R2 add carry", 0, 8'h01);
    run("R2 wr", 11, 8'h80); run("R12 lda", 9, 8'h0E); run("R2 addc", 1, 8'h01);
    run("R2 add plain", 0, 8'h20);
  endtask

  task automatic t_subb();
    run("R11 wr", 11, 8'h00); run("R12 lda", 9, 8'h00); run("R3 borrow", 2, 8'h01);
    run("R12 lda", 9, 8'h80); run("R3 ov", 2, 8'h00);
    run("R12 lda", 9, 8'h50); run("R3 plain", 2, 8'h23);
  endtask

  task automatic t_inc();
    run("R4 wr", 11, 8'hC4); run("R12 lda", 9, 8'hFF); run("R4 wrap", 3, 0);
    run("R4 inc", 3, 0);
  endtask

  task automatic t_logic();
    run("R12 lda", 9, 8'hF0); run("R5 and", 4, 8'h3C);
    run("R5 or", 5, 8'h0F); run("R5 xor", 6, 8'hA5);
  endtask

  task automatic t_mul();
    run("R12 lda", 9, 8'h10); run("R12 ldb", 10, 8'h10); run("R6 mul big", 7, 0);
    run("R12 lda", 9, 8'h0C); run("R12 ldb", 10, 8'h0A); run("R6 mul small", 7, 0);
    run("R12 lda", 9, 8'hFF); run("R12 ldb", 10, 8'hFF); run("R6 mul max", 7, 0);
  endtask

  task automatic t_div();
    run("R11 wr", 11, 8'h84);
    run("R12 lda", 9, 8'hFB); run("R12 ldb", 10, 8'h12); run("R7 div", 8, 0);
    run("R12 lda", 9, 8'h07); run("R12 ldb", 10, 8'h09); run("R7 div small", 8, 0);
  endtask

  task automatic t_div0();
    run("R11 wr", 11, 8'h80);
    run("R12 lda", 9, 8'h5A); run("R12 ldb", 10, 8'h00); run("R8 div zero", 8, 0);
  endtask

  task automatic t_busy();
    int lat;
    run("R12 lda", 9, 8'h0B); run("R12 ldb", 10, 8'h07);
    @(negedge clk); op = 4'd7; start = 1'b1;
    @(posedge clk);
    @(negedge clk); chk("R9 busy high", busy, 1); op = 4'd9; operand = 8'h33;
    @(posedge clk);
    @(negedge clk); start = 1'b0; lat = 2;
    chk("R9 A frozen", acc, m_a);
    while (!done && lat < 40) begin @(negedge clk); lat++; end
    model(7, 0);
    chk("R9 latency", lat, 9);
    chk_state("R9 start ignored");
    @(negedge clk); chk("R9 busy low", busy, 0); chk_state("R9 after");
  endtask

  task automatic t_parity();
    run("R10 lda", 9, 8'h01);
    run("R10 forced bit0", 11, 8'h00);
    run("R10 lda even", 9, 8'h03);
    run("R10 forced bit0 set", 11, 8'h01);
  endtask

  task automatic t_pswwr();
    run("R11 wr", 11, 8'h3A);
    run("R12 lda", 9, 8'hC8); run("R11 add keeps user bits", 0, 8'h70);
    run("R11 mul keeps user bits", 7, 0);
    chk("R11 user bits", psw & 8'h3A, 8'h3A);
  endtask

  task automatic t_unused();
    run("R13 op12", 12, 8'hFF); run("R13 op15", 15, 8'h00);
  endtask

  task automatic finish_run();
    if (finished) return;
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_add(); t_subb(); t_inc(); t_logic(); t_mul(); t_div(); t_div0();
    t_busy(); t_parity(); t_pswwr(); t_unused();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end
endmodule